// File: doc/BRIEF.md
# Flash Page Erase Sequencer

This block erases one page of on-chip flash per command. A processor programs a page-select register with the high byte of a flash address and a timing register with a value that depends on the system clock. It then writes the erase command code to the control register. The block raises a busy flag and runs a timer whose length scales with the timing value. When the timer expires, every byte of the chosen page reads as erased, and the busy flag drops.

If the erase is launched while the processor is fetching code from flash, the block also holds a stall line high for the whole erase. Execution therefore simply resumes with the next instruction once the page is blank, and software does not have to poll. The flash array is a behavioural model. It has 32 pages of 2 KB over a 16-bit address space, and a byte that has not been erased returns a fixed, address-derived value.

The erase lasts the timing value times a parameter `PRESCALE` clock cycles. The default of 15238 gives about 20 ms at 32 MHz for the timing value 0x2A.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy and cpu_stall are 0, the page-select and timing registers read 0x00, and every flash byte reads its unerased value.
- R2: A read of the control register (reg_sel = 0) returns busy in bit 7 and zeros in bits 6..0. Select code 3 reads 0x00 and ignores writes.
- R3: A write of 0x01 to the control register while idle starts an erase, and busy reads 1 from the next cycle. Any other value written to the control register has no effect.
- R4: busy stays high for exactly max(T,1) × PRESCALE cycles, where T is the timing register (reg_sel = 2) value at launch.
- R5: The page erased is bits 7..3 of the page-select register (reg_sel = 1) at launch, which is the 2 KB page holding address {page_select, 8'h00}. The register reads back all 8 bits written.
- R6: Once busy falls, every byte of the erased page reads 0xFF. Every byte of a page that has not been erased reads {1'b0, addr[6:0]}.
- R7: An erase launched with fetch_from_flash = 1 holds cpu_stall high from the cycle after launch until busy falls, and it falls in the same cycle as busy. An erase launched with fetch_from_flash = 0 never raises cpu_stall.
- R8: An erase command written while busy is ignored and does not restart or extend the timer. This includes a command in the last busy cycle.
- R9: Writes to the page-select or timing register while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 page select, 2 timing, 3 unused |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| fetch_from_flash | input | 1 | Processor is currently executing from flash |
| busy | output | 1 | Erase in progress |
| cpu_stall | output | 1 | Instruction fetch hold-off |
| rd_addr | input | 16 | Flash byte read address |
| rd_data | output | 8 | Flash byte read data (combinational) |

## Verification
Two functions can coincide in one cycle. A new erase command can arrive in the very cycle the running erase completes, while busy is still high. The bench provokes this by writing the command on every busy cycle, including the last. It then judges the result by the measured busy length and by busy staying low afterwards. The same completion edge also sets the page flag and drops the stall. The reference model checks that the flash read data, busy and cpu_stall all change together on that edge.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 2048;
    localparam int OFFS_W     = $clog2(PAGE_BYTES);
    localparam int PAGE_IDX_W = ADDR_W - OFFS_W;
    localparam int NUM_PAGES  = 1 << PAGE_IDX_W;
    localparam int UNITS_W    = 8;

    localparam logic [DATA_W-1:0] CMD_ERASE  = 8'h01;
    localparam logic [DATA_W-1:0] BLANK_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PAGE = 2'd1,
        SEL_TIME = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PAGE_IDX_W-1:0] page;
        logic [UNITS_W-1:0]    units;
        logic                  stall;
    } erase_req_t;

    // Value returned by a byte that has not been erased
    function automatic logic [DATA_W-1:0] fill_value(input logic [6:0] low_addr);
        return {1'b0, low_addr};
    endfunction

    // Page index held in the upper bits of the page-select byte
    function automatic logic [PAGE_IDX_W-1:0] page_from_hi(input logic [7:0] hi);
        return hi[7 -: PAGE_IDX_W];
    endfunction

endpackage

// File: rtl/flash_erase_regs.sv
module flash_erase_regs
    import flash_erase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fetch_flash,
    input  logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              start,
    output erase_req_t        req
);

    logic [7:0] page_hi_q;
    logic [7:0] timing_q;
    reg_sel_e   sel_e;

    assign sel_e = reg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_hi_q <= '0;
            timing_q  <= '0;
        end else if (we && !busy) begin
            case (sel_e)
                SEL_PAGE: page_hi_q <= wdata;
                SEL_TIME: timing_q  <= wdata;
                default:  ;
            endcase
        end
    end

    assign start = we && !busy && (sel_e == SEL_CTRL) && (wdata == CMD_ERASE);

    always_comb begin
        req.page  = page_from_hi(page_hi_q);
        req.units = (timing_q == '0) ? UNITS_W'(1) : timing_q;
        req.stall = fetch_flash;
    end

    always_comb begin
        case (sel_e)
            SEL_CTRL: rdata = {busy, 7'b0};
            SEL_PAGE: rdata = page_hi_q;
            SEL_TIME: rdata = timing_q;
            default:  rdata = '0;
        endcase
    end

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(page_hi_q) && $stable(timing_q)));

endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer
    import flash_erase_pkg::*;
#(
    parameter int PRESCALE = 15238
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  erase_req_t            req,
    output logic                  busy,
    output logic                  stall,
    output logic                  done,
    output logic [PAGE_IDX_W-1:0] page
);

    localparam int CNT_W = UNITS_W + $clog2(PRESCALE + 1);
    localparam logic [CNT_W-1:0] PS = CNT_W'(PRESCALE);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = ({{(CNT_W-UNITS_W){1'b0}}, req.units} * PS) - CNT_W'(1);
    assign done     = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            stall <= 1'b0;
            cnt_q <= '0;
            page  <= '0;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy  <= 1'b0;
                stall <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end else if (start) begin
            busy  <= 1'b1;
            stall <= req.stall;
            cnt_q <= load_val;
            page  <= req.page;
        end
    end

    // R3
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R7
    stall_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> busy);

    // R7
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> $fell(busy));

endmodule

// File: rtl/flash_page_model.sv
module flash_page_model
    import flash_erase_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  done,
    input  logic [PAGE_IDX_W-1:0] done_page,
    input  logic [ADDR_W-1:0]     addr,
    output logic [DATA_W-1:0]     data
);

    logic [NUM_PAGES-1:0] erased_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            erased_q <= '0;
        end else if (done) begin
            erased_q[done_page] <= 1'b1;
        end
    end

    assign data = erased_q[addr[ADDR_W-1 -: PAGE_IDX_W]] ? BLANK_BYTE
                                                         : fill_value(addr[6:0]);

    // R6
    erase_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        (erased_q != $past(erased_q)) |-> $past(done));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int PRESCALE = 15238
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        fetch_from_flash,
    output logic        busy,
    output logic        cpu_stall,
    input  logic [15:0] rd_addr,
    output logic [7:0]  rd_data
);

    erase_req_t            req;
    logic                  start;
    logic                  done;
    logic [PAGE_IDX_W-1:0] act_page;

    flash_erase_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .fetch_flash(fetch_from_flash),
        .busy       (busy),
        .rdata      (reg_rdata),
        .start      (start),
        .req        (req)
    );

    flash_erase_timer #(.PRESCALE(PRESCALE)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .req  (req),
        .busy (busy),
        .stall(cpu_stall),
        .done (done),
        .page (act_page)
    );

    flash_page_model u_mem (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .done_page(act_page),
        .addr     (rd_addr),
        .data     (rd_data)
    );

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> (reg_rdata == {busy, 7'b0}));

endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;

    localparam int PS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        fetch_from_flash = 1'b0;
    logic        busy;
    logic        cpu_stall;
    logic [15:0] rd_addr = 16'h0000;
    logic [7:0]  rd_data;

    int tests = 0;
    int fails = 0;
    bit seen_edge = 0;
    bit finished = 0;

    // reference model state
    bit        m_busy = 0, m_stall = 0;
    int        m_rem = 0;
    int        m_pg = 0;
    bit [7:0]  m_page = 0, m_time = 0;
    bit [31:0] m_erased = 0;

    always #10 clk = ~clk;

    flash_erase_seq #(.PRESCALE(PS)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_from_flash(fetch_from_flash), .busy(busy), .cpu_stall(cpu_stall),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        seen_edge <= 1;
        if (rst) begin
            m_busy = 0; m_stall = 0; m_rem = 0; m_pg = 0;
            m_page = 0; m_time = 0; m_erased = 0;
        end else if (m_busy) begin
            if (m_rem == 1) begin
                m_busy = 0; m_stall = 0; m_erased[m_pg] = 1'b1;
            end else begin
                m_rem = m_rem - 1;
            end
        end else if (reg_we) begin
            if (reg_sel == 2'd0 && reg_wdata == 8'h01) begin
                m_busy = 1;
                m_stall = fetch_from_flash;
                m_rem = ((m_time == 0) ? 1 : int'(m_time)) * PS;
                m_pg = int'(m_page) / 8;
            end else if (reg_sel == 2'd1) m_page = reg_wdata;
            else if (reg_sel == 2'd2) m_time = reg_wdata;
        end
    end

    function automatic bit [7:0] exp_reg(input bit [1:0] s);
        case (s)
            2'd0: return {m_busy, 7'b0};
            2'd1: return m_page;
            2'd2: return m_time;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit [7:0] exp_flash(input bit [15:0] a);
        return m_erased[a[15:11]] ? 8'hFF : {1'b0, a[6:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (seen_edge && !finished) begin
            chk("R4 busy vs model", busy, m_busy);
            chk("R7 cpu_stall vs model", cpu_stall, m_stall);
            chk("R2/R9 reg_rdata vs model", reg_rdata, exp_reg(reg_sel));
            chk("R6 rd_data vs model", rd_data, exp_flash(rd_addr));
        end
    end

    task automatic wr(input bit [1:0] s, input bit [7:0] d);
        @(negedge clk); #1;
        reg_we = 1; reg_sel = s; reg_wdata = d;
        @(negedge clk); #1;
        reg_we = 0;
    endtask

    task automatic rd_reg(input bit [1:0] s, input string tag, input bit [7:0] exp);
        @(negedge clk); #1;
        reg_sel = s;
        @(negedge clk); #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic rd_fl(input bit [15:0] a, input string tag, input bit [7:0] exp);
        @(negedge clk); #1;
        rd_addr = a;
        #2;
        chk(tag, rd_data, exp);
    endtask

    // waits for busy to drop; optionally spams commands and config writes
    task automatic run_erase(input bit spam, input int exp_len, input string tag);
        int n = 0;
        while (busy) begin
            n++;
            if (spam) begin
                reg_we = 1;
                reg_sel = (n % 3 == 2) ? 2'd1 : 2'd0;
                reg_wdata = (n % 3 == 2) ? 8'h10 : 8'h01;
            end
            @(negedge clk); #1;
        end
        reg_we = 0; reg_sel = 2'd0;
        chk(tag, n, exp_len);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 busy after reset", busy, 0);
        chk("R1 stall after reset", cpu_stall, 0);
        rd_reg(2'd1, "R1 page reg reset", 8'h00);
        rd_reg(2'd2, "R1 timing reg reset", 8'h00);
        rd_fl(16'h0805, "R1 unerased byte", 8'h05);
        rd_fl(16'hFFFF, "R6 unerased pattern", 8'h7F);

        // configuration and read-back
        wr(2'd1, 8'h0B);
        rd_reg(2'd1, "R5 page reg readback", 8'h0B);
        wr(2'd2, 8'h02);
        rd_reg(2'd2, "R5 timing reg readback", 8'h02);
        wr(2'd3, 8'h55);
        rd_reg(2'd3, "R2 unused select reads zero", 8'h00);

        // non-erase control value has no effect
        wr(2'd0, 8'h02);
        chk("R3 non-command value no start", busy, 0);
        wr(2'd0, 8'h81);
        chk("R3 other value no start", busy, 0);

        // erase page 1 from flash fetch, with busy writes spammed
        fetch_from_flash = 1;
        wr(2'd0, 8'h01);
        fetch_from_flash = 0;
        chk("R3 busy after command", busy, 1);
        chk("R7 stall after command", cpu_stall, 1);
        chk("R2 ctrl reads busy", reg_rdata, 8'h80);
        run_erase(1, 2 * PS, "R8 R4 erase length with commands while busy");
        chk("R7 stall released with busy", cpu_stall, 0);
        @(negedge clk); #1;
        chk("R8 no erase after last-cycle command", busy, 0);
        rd_reg(2'd1, "R9 page write during busy ignored", 8'h0B);
        rd_fl(16'h0800, "R6 page1 first byte", 8'hFF);
        rd_fl(16'h0FFF, "R6 page1 last byte", 8'hFF);
        rd_fl(16'h1000, "R6 page2 untouched", 8'h00);
        rd_fl(16'h07FF, "R6 page0 untouched", 8'h7F);

        // timing 0 erases with one unit, no stall
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hF8);
        wr(2'd0, 8'h01);
        chk("R7 no stall when not fetching", cpu_stall, 0);
        run_erase(0, PS, "R4 zero timing length");
        rd_fl(16'hF800, "R5 page31 erased", 8'hFF);

        // longer erase of page 0, config write while busy
        wr(2'd2, 8'h05);
        wr(2'd1, 8'h03);
        fetch_from_flash = 1;
        wr(2'd0, 8'h01);
        fetch_from_flash = 0;
        wr(2'd2, 8'h09);
        run_erase(0, 5 * PS - 2, "R4 timing five length");
        rd_reg(2'd2, "R9 timing write during busy ignored", 8'h05);
        rd_fl(16'h0000, "R5 page0 erased", 8'hFF);
        rd_fl(16'h0812, "R6 page1 still erased", 8'hFF);
        rd_fl(16'h2000, "R6 page4 untouched", 8'h00);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule